// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with APB Register Access

This block is a down-counting watchdog timer. Software reaches it through an APB slave port. Every cycle in which the separate watchdog tick enable is high, the counter steps down by one. The first time it runs out, it raises an interrupt request and starts again from the reload value. If software has not cleared the interrupt when the counter runs out a second time, the block latches a reset request and the counter halts.

Writes are protected by a lock. Any write other than a fixed 32-bit key to the lock register locks the block, and while locked every other write is discarded. A test mode lets software drive the interrupt and reset pins directly from a register.

A parameter builds a variant with two differences. Its control register can no longer be changed once the interrupt enable has been set. Its test-mode registers are absent.

Top module: `apb_watchdog`

## Requirements
- R1: After reset, the following hold. The reload value and the counter are 0xFFFFFFFF and counting is active. The control, raw interrupt, reset status, lock, test-enable and test-output state are all zero. Both output pins are low.
- R2: A write to the reload register (word offset 0x000) stores the value and loads the counter with it in the same cycle. It also restarts counting if the counter had halted. The counter reads back at offset 0x004.
- R3: On each cycle with the tick enable high, a running counter decreases by one. A tick at a count of 1 (or 0) is an expiry. If the raw interrupt (bit 0 of offset 0x010) is clear at expiry, the block sets it and reloads the counter from the reload value.
- R4: An expiry while the raw interrupt is already set latches the reset status, reloads the counter and halts it. Further ticks leave the count unchanged.
- R5: A write of any value to the clear register (offset 0x00C) clears the raw interrupt and reloads the counter.
- R6: Control register (offset 0x008) bit 0 enables the interrupt and bit 1 enables the reset request. Other written bits read back as zero. The interrupt pin equals raw interrupt AND interrupt enable. The reset pin equals reset status AND reset enable. Offset 0x014 reads the masked interrupt. Each pin changes one clock after the state that drives it.
- R7: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and any other value locks it. A read of 0xC00 returns 1 while locked. While locked, writes to every other register are ignored.
- R8: When test-enable bit 0 (offset 0xF00) is set, the interrupt pin follows bit 1 of the test-output register (offset 0xF04) and the reset pin follows its bit 0.
- R9: In the write-once variant, writes to the control register are ignored once its interrupt enable is set. Offsets 0xF00, 0xF04 and 0x00C read as 0, and writes to 0xF00 and 0xF04 have no effect.
- R10: The following reads return 0: reads of write-only registers, of unmapped offsets, and of addresses that are not word-aligned. Writes to the read-only registers (counter, raw, masked, identification) are ignored.
- R11: The twelve identification words at 0xFD0 + 4k (k = 0..11) read as ID_SEED + 17*k, truncated to 8 bits, in bits 7:0, with zeros above.
- R12: Every transfer completes with pready high and pslverr low, with no wait states.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Watchdog count enable |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| irq_o | output | 1 | Watchdog interrupt request |
| rst_req_o | output | 1 | Watchdog reset request |

## Verification
Tick bursts of chosen lengths are applied around a small reload value, so that each burst stops exactly before an expiry, at the first expiry, or at the second expiry. This separates a plain decrement from an interrupt, and an interrupt from a halted reset. A clear issued between two bursts shows that clearing restarts the two-stage sequence. Control values with and without each enable, and test-output patterns opposite to the normal pin values, separate masked from raw behaviour and normal from test drive. Writes issued while locked, to read-only offsets, and to the variant's frozen control register are each followed by read-back, to show that nothing changed.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned IDX_W = 10;

  localparam logic [IDX_W-1:0] W_RELOAD   = 10'h000;
  localparam logic [IDX_W-1:0] W_COUNT    = 10'h001;
  localparam logic [IDX_W-1:0] W_CTRL     = 10'h002;
  localparam logic [IDX_W-1:0] W_CLEAR    = 10'h003;
  localparam logic [IDX_W-1:0] W_RAW      = 10'h004;
  localparam logic [IDX_W-1:0] W_MASKED   = 10'h005;
  localparam logic [IDX_W-1:0] W_LOCK     = 10'h300;
  localparam logic [IDX_W-1:0] W_TEST_EN  = 10'h3C0;
  localparam logic [IDX_W-1:0] W_TEST_OUT = 10'h3C1;
  localparam logic [IDX_W-1:0] W_ID_FIRST = 10'h3F4;

  localparam int unsigned ID_WORDS = 12;
  localparam int unsigned ID_SLOTS = 16;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic rst_en;
    logic irq_en;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regbank.sv
module wdt_regbank
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 12,
  parameter bit          WRITE_ONCE = 1'b0,
  parameter logic [7:0]  ID_SEED    = 8'h3A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [DATA_W-1:0] count,
  input  logic              ris,
  output logic              load_wr,
  output logic              clear_wr,
  output logic [DATA_W-1:0] reload_val,
  output wdt_ctrl_t         ctrl,
  output logic              test_en,
  output logic [1:0]        test_out
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic              wr_en;
  logic              wr_open;
  logic              rd_setup;
  logic              locked;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] rd_mux;
  logic [3:0]        id_idx;
  logic [DATA_W-1:0] id_word [ID_SLOTS];

  assign widx     = paddr[ADDR_W-1:2];
  assign aligned  = (paddr[1:0] == 2'b00);
  assign wr_en    = psel && penable && pwrite && aligned;
  assign wr_open  = wr_en && !locked;
  assign rd_setup = psel && !penable && !pwrite;

  assign load_wr    = wr_open && (widx == WIDX_W'(W_RELOAD));
  assign clear_wr   = wr_open && (widx == WIDX_W'(W_CLEAR));
  assign reload_val = load_wr ? pwdata : load_val;

  genvar g;
  generate
    for (g = 0; g < ID_SLOTS; g++) begin : g_id
      if (g < ID_WORDS) begin : g_used
        assign id_word[g] = {{(DATA_W-8){1'b0}}, 8'(ID_SEED + 8'(g * 17))};
      end else begin : g_spare
        assign id_word[g] = '0;
      end
    end
  endgenerate

  assign id_idx = 4'(widx - WIDX_W'(W_ID_FIRST));

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (widx >= WIDX_W'(W_ID_FIRST)) begin
        rd_mux = id_word[id_idx];
      end else begin
        case (widx)
          WIDX_W'(W_RELOAD):  rd_mux = load_val;
          WIDX_W'(W_COUNT):   rd_mux = count;
          WIDX_W'(W_CTRL):    rd_mux = DATA_W'({ctrl.rst_en, ctrl.irq_en});
          WIDX_W'(W_RAW):     rd_mux = DATA_W'(ris);
          WIDX_W'(W_MASKED):  rd_mux = DATA_W'(ris && ctrl.irq_en);
          WIDX_W'(W_LOCK):    rd_mux = DATA_W'(locked);
          WIDX_W'(W_TEST_EN): rd_mux = WRITE_ONCE ? '0 : DATA_W'(test_en);
          default:            rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_val <= '1;
      ctrl     <= '0;
      locked   <= 1'b0;
      test_en  <= 1'b0;
      test_out <= 2'b00;
      prdata   <= '0;
    end else begin
      if (wr_en && (widx == WIDX_W'(W_LOCK))) begin
        locked <= (pwdata != DATA_W'(UNLOCK_KEY));
      end
      if (wr_open) begin
        case (widx)
          WIDX_W'(W_RELOAD): load_val <= pwdata;
          WIDX_W'(W_CTRL): begin
            if (!(WRITE_ONCE && ctrl.irq_en)) begin
              ctrl.irq_en <= pwdata[0];
              ctrl.rst_en <= pwdata[1];
            end
          end
          WIDX_W'(W_TEST_EN):  if (!WRITE_ONCE) test_en <= pwdata[0];
          WIDX_W'(W_TEST_OUT): if (!WRITE_ONCE) test_out <= pwdata[1:0];
          default: ;
        endcase
      end
      if (rd_setup) begin
        prdata <= rd_mux;
      end
    end
  end

  // R7: a locked block keeps its settings through non-key writes
  a_r7_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (locked && wr_en && (widx != WIDX_W'(W_LOCK))) |=>
      ($stable(ctrl) && $stable(load_val) && $stable(test_en) && $stable(test_out)));

  generate
    if (WRITE_ONCE) begin : g_once_chk
      // R9: once the interrupt enable is set it never drops before reset
      a_r9_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
        ctrl.irq_en |=> (ctrl.irq_en && $stable(ctrl)));
      // R9: test mode never switches on in this variant
      a_r9_no_test_mode: assert property (@(posedge clk) disable iff (rst)
        !test_en);
    end
  endgenerate
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              load_wr,
  input  logic              clear_wr,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] count,
  output logic              ris,
  output logic              rst_stat
);
  logic running;
  logic expire;
  logic step;

  assign expire = (count == '0) || (count == DATA_W'(1));
  assign step   = tick_en && running;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '1;
      running  <= 1'b1;
      ris      <= 1'b0;
      rst_stat <= 1'b0;
    end else if (load_wr || clear_wr) begin
      count <= reload_val;
      if (load_wr)  running <= 1'b1;
      if (clear_wr) ris     <= 1'b0;
    end else if (step) begin
      if (expire) begin
        count <= reload_val;
        if (ris) begin
          rst_stat <= 1'b1;
          running  <= 1'b0;
        end else begin
          ris <= 1'b1;
        end
      end else begin
        count <= count - DATA_W'(1);
      end
    end
  end

  // R3: first expiry raises the raw interrupt
  a_r3_first_expiry: assert property (@(posedge clk) disable iff (rst)
    (step && expire && !ris && !load_wr && !clear_wr) |=> ris);
  // R4: a halted counter holds its value until a reload
  a_r4_halted_holds: assert property (@(posedge clk) disable iff (rst)
    (!running && !load_wr && !clear_wr) |=> $stable(count));
  // R4: reset status, once latched, stays latched
  a_r4_status_sticky: assert property (@(posedge clk) disable iff (rst)
    rst_stat |=> rst_stat);
  // R5: clear drops the raw interrupt
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    clear_wr |=> !ris);
endmodule

// File: rtl/wdt_out_stage.sv
module wdt_out_stage
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  wdt_ctrl_t  ctrl,
  input  logic       ris,
  input  logic       rst_stat,
  input  logic       test_en,
  input  logic [1:0] test_out,
  output logic       irq_o,
  output logic       rst_req_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else if (test_en) begin
      irq_o     <= test_out[1];
      rst_req_o <= test_out[0];
    end else begin
      irq_o     <= ris && ctrl.irq_en;
      rst_req_o <= rst_stat && ctrl.rst_en;
    end
  end

  // R6: a disabled interrupt never reaches the pin in normal mode
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (!test_en && !ctrl.irq_en) |=> !irq_o);
  // R6: the reset pin needs latched status in normal mode
  a_r6_rst_needs_status: assert property (@(posedge clk) disable iff (rst)
    (!test_en && !rst_stat) |=> !rst_req_o);
  // R8: test mode drives the pins from the test-output bits
  a_r8_test_drive: assert property (@(posedge clk) disable iff (rst)
    test_en |=> ((irq_o == $past(test_out[1])) && (rst_req_o == $past(test_out[0]))));
endmodule

// File: rtl/apb_watchdog.sv
module apb_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 12,
  parameter bit          WRITE_ONCE = 1'b0,
  parameter logic [7:0]  ID_SEED    = 8'h3A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] reload_val;
  logic              ris;
  logic              rst_stat;
  logic              load_wr;
  logic              clear_wr;
  wdt_ctrl_t         ctrl;
  logic              test_en;
  logic [1:0]        test_out;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  wdt_regbank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WRITE_ONCE(WRITE_ONCE), .ID_SEED(ID_SEED)
  ) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .count(count), .ris(ris),
    .load_wr(load_wr), .clear_wr(clear_wr), .reload_val(reload_val),
    .ctrl(ctrl), .test_en(test_en), .test_out(test_out)
  );

  wdt_down_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .load_wr(load_wr),
    .clear_wr(clear_wr), .reload_val(reload_val), .count(count),
    .ris(ris), .rst_stat(rst_stat)
  );

  wdt_out_stage u_out (
    .clk(clk), .rst(rst), .ctrl(ctrl), .ris(ris), .rst_stat(rst_stat),
    .test_en(test_en), .test_out(test_out), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );
endmodule

// File: tb/test_apb_watchdog.sv
module test_apb_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        psel_a = 1'b0, psel_b = 1'b0;
  logic        penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata_a, prdata_b;
  logic        pready_a, pready_b, pslverr_a, pslverr_b;
  logic        irq_a, irq_b, rstq_a, rstq_b;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t       sb_q[$];
  logic [31:0] got;
  event        rd_evt;

  localparam logic [31:0] KEY = 32'h1ACCE551;

  always #5 clk = ~clk;

  apb_watchdog #(.WRITE_ONCE(1'b0), .ID_SEED(8'h3A)) i_apb_watchdog (
    .clk(clk), .rst(rst), .tick_en(tick_en), .psel(psel_a), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a),
    .pready(pready_a), .pslverr(pslverr_a), .irq_o(irq_a), .rst_req_o(rstq_a));

  apb_watchdog #(.WRITE_ONCE(1'b1), .ID_SEED(8'h5C)) i_apb_watchdog_wo (
    .clk(clk), .rst(rst), .tick_en(tick_en), .psel(psel_b), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_b),
    .pready(pready_b), .pslverr(pslverr_b), .irq_o(irq_b), .rst_req_o(rstq_b));

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item for each completed read
  initial begin
    forever begin
      item_t it;
      @(rd_evt);
      it = sb_q.pop_front();
      chk(got, it.exp, it.tag);
    end
  end

  task automatic wr(input bit wo, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel_a = ~wo; psel_b = wo; paddr = a; pwdata = d; pwrite = 1'b1; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input bit wo, input logic [11:0] a, input logic [31:0] exp, input string tag);
    sb_q.push_back('{exp, tag});
    @(negedge clk);
    psel_a = ~wo; psel_b = wo; paddr = a; pwrite = 1'b0; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    got = wo ? prdata_b : prdata_a;
    chk({30'd0, (wo ? pready_b : pready_a), (wo ? pslverr_b : pslverr_a)}, 32'd2, "R12 handshake");
    -> rd_evt;
    @(negedge clk);
    psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pins(input bit wo, input logic irq_e, input logic rst_e, input string tag);
    repeat (2) @(negedge clk);
    chk({30'd0, (wo ? irq_b : irq_a), (wo ? rstq_b : rstq_a)}, {30'd0, irq_e, rst_e}, tag);
  endtask

  function automatic logic [31:0] id_exp(input logic [7:0] seed, input int k);
    return {24'd0, 8'(seed + 8'(17 * k))};
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_test();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    pins(1'b0, 1'b0, 1'b0, "R1 pins after reset");
    rd(0, 12'h000, 32'hFFFF_FFFF, "R1 reload");
    rd(0, 12'h004, 32'hFFFF_FFFF, "R1 count");
    rd(0, 12'h008, 32'd0, "R1 control");
    rd(0, 12'h010, 32'd0, "R1 raw");
    rd(0, 12'hC00, 32'd0, "R1 lock");
    rd(0, 12'hF00, 32'd0, "R1 test enable");
    // R11 identification
    rd(0, 12'hFD0, id_exp(8'h3A, 0), "R11 id first");
    rd(0, 12'hFFC, id_exp(8'h3A, 11), "R11 id last");
    rd(1, 12'hFD4, id_exp(8'h5C, 1), "R11 id variant");
    // R10 empty reads
    rd(0, 12'h020, 32'd0, "R10 unmapped");
    rd(0, 12'h00C, 32'd0, "R10 clear write-only");
    rd(0, 12'hF04, 32'd0, "R10 test-out write-only");
    rd(0, 12'h002, 32'd0, "R10 unaligned");
    // R2 reload write
    wr(0, 12'h000, 32'd5);
    rd(0, 12'h000, 32'd5, "R2 reload value");
    rd(0, 12'h004, 32'd5, "R2 count loaded");
    ticks(2);
    rd(0, 12'h004, 32'd3, "R3 decrement");
    // R6 control bits
    wr(0, 12'h008, 32'hFFFF_FFFD);
    rd(0, 12'h008, 32'd1, "R6 control masked bits");
    // R3 first expiry: 3 -> 2 -> 1 -> expire
    ticks(3);
    rd(0, 12'h010, 32'd1, "R3 raw set");
    rd(0, 12'h014, 32'd1, "R6 masked set");
    rd(0, 12'h004, 32'd5, "R3 reloaded");
    pins(0, 1'b1, 1'b0, "R6 irq pin");
    // R5 clear
    wr(0, 12'h00C, 32'h1234);
    rd(0, 12'h010, 32'd0, "R5 raw cleared");
    rd(0, 12'h004, 32'd5, "R5 reloaded");
    pins(0, 1'b0, 1'b0, "R5 irq low");
    // R4 second expiry
    ticks(5);
    rd(0, 12'h010, 32'd1, "R3 raw again");
    ticks(5);
    pins(0, 1'b1, 1'b0, "R6 reset masked");
    ticks(3);
    rd(0, 12'h004, 32'd5, "R4 halted");
    wr(0, 12'h008, 32'd2);
    pins(0, 1'b0, 1'b1, "R6 reset enable only");
    rd(0, 12'h014, 32'd0, "R6 masked off");
    wr(0, 12'h008, 32'd3);
    // R7 lock
    wr(0, 12'hC00, 32'd0);
    rd(0, 12'hC00, 32'd1, "R7 locked");
    wr(0, 12'h008, 32'd0);
    rd(0, 12'h008, 32'd3, "R7 control kept");
    wr(0, 12'h000, 32'd9);
    rd(0, 12'h000, 32'd5, "R7 reload kept");
    wr(0, 12'hC00, KEY);
    rd(0, 12'hC00, 32'd0, "R7 unlocked");
    // R10 read-only writes
    wr(0, 12'h004, 32'd7);
    rd(0, 12'h004, 32'd5, "R10 count read-only");
    wr(0, 12'h010, 32'd0);
    rd(0, 12'h010, 32'd1, "R10 raw read-only");
    // R8 test mode
    wr(0, 12'hF00, 32'd1);
    rd(0, 12'hF00, 32'd1, "R8 test enable");
    wr(0, 12'hF04, 32'd2);
    pins(0, 1'b1, 1'b0, "R8 drive irq");
    wr(0, 12'hF04, 32'd1);
    pins(0, 1'b0, 1'b1, "R8 drive reset");
    wr(0, 12'hF04, 32'd0);
    pins(0, 1'b0, 1'b0, "R8 override normal");
    wr(0, 12'hF00, 32'd0);
    pins(0, 1'b1, 1'b1, "R8 back to normal");
    // R2 restart after halt
    wr(0, 12'h000, 32'd4);
    ticks(1);
    rd(0, 12'h004, 32'd3, "R2 restarted");
    // R9 write-once variant
    wr(1, 12'h008, 32'd2);
    rd(1, 12'h008, 32'd2, "R9 control writable");
    wr(1, 12'h008, 32'd1);
    rd(1, 12'h008, 32'd1, "R9 enable set");
    wr(1, 12'h008, 32'd0);
    rd(1, 12'h008, 32'd1, "R9 control frozen");
    wr(1, 12'hF00, 32'd1);
    rd(1, 12'hF00, 32'd0, "R9 test enable absent");
    wr(1, 12'hF04, 32'd3);
    pins(1, 1'b0, 1'b0, "R9 no test drive");
    rd(1, 12'h00C, 32'd0, "R9 clear read");
    repeat (4) @(negedge clk);
    finish_test();
  end
endmodule